// File: doc/BRIEF.md
# Serial Peripheral Master Port with Frame Queues

This block is a register-mapped serial port that only ever drives the bus as the SPI master. Software configures clock polarity, clock phase, frame length and a two-stage bit-rate divider. It pushes words into an 8-entry transmit queue and pulls received words from an 8-entry receive queue. The port sends each queued word as one frame. While a frame is on the wire the active-low frame select is held low, and the bits received during that frame are collected into a receive word.

Software polls a status word that carries queue-empty, queue-not-full, queue-not-empty, queue-full and busy flags. It waits for busy to clear before it treats a transfer as finished. A loopback switch feeds the outgoing serial data back into the receiver, so the port can test itself. A sticky overrun flag records frames that were lost because the receive queue was full. A single level interrupt combines the raw interrupt conditions under per-source enables.

Top module: `spim_top`

## Requirements
- R1: After reset the status word reads 0x03, the serial clock is low, frame select is high, the interrupt output is low, the raw interrupt word reads 0x2, and the control and prescale registers read 0. Word index = byte offset / 4. Offsets: control A 0x00, control B 0x04, data 0x08, status 0x0C, prescale 0x10, interrupt status/clear 0x14.
- R2: The SCLK half period is (P/2)·(1+S) clock cycles. P is the prescale register with bit 0 ignored, and a value below 2 acts as 2. S is control A bits [15:8]. The first SCLK edge comes one half period after frame select falls.
- R3: While no frame is being sent, SCLK rests at control A bit 6 (polarity), including while the port is disabled.
- R4: With control A bit 7 (phase) = 0, MOSI is valid before the first edge, and the port samples on leading edges and shifts on trailing edges. With phase = 1, it shifts on leading edges and samples on trailing edges. Bits go out MSB first.
- R5: Frame length is control A bits [3:0] + 1; values 0 to 2 act as 4 bits. Each frame has exactly 2·length SCLK edges. The received word is right-justified with zeros above it.
- R6: Every word accepted into the transmit queue produces exactly one received word, in order. A read of the data register pops the receive queue. Each queue holds 8 words.
- R7: Status bits: 0 = transmit queue empty, 1 = transmit queue not full, 2 = receive queue not empty, 3 = receive queue full, 4 = busy.
- R8: Busy is 1 while a frame is shifting or the transmit queue holds a word.
- R9: With control B bit 4 (enable) = 0, no frame starts and SCLK and frame select stay idle. Queue contents are kept, and sending resumes when the bit is set again.
- R10: A frame that completes while the receive queue is full is discarded and sets raw interrupt bit 2. A write of any value to offset 0x14 clears that bit.
- R11: A data write while the transmit queue is full is dropped. A data read while the receive queue is empty returns 0.
- R12: With control B bit 3 (loopback) = 1, the receiver takes MOSI and ignores the MISO pin.
- R13: Raw interrupt bit 0 is 1 when the receive queue holds at least 4 words, and bit 1 is 1 when the transmit queue holds at most 4. The interrupt output is the OR of the raw bits ANDed with control B bits [2:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_widx | input | 3 | Register word index (byte offset / 4) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the same cycle as the access |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_fs_n | output | 1 | Frame select, low during a frame |
| irq | output | 1 | Masked interrupt |

## Verification
A wrong divider count shows at the pins within one half period: the first SCLK toggle after frame select falls lands early or late, so the bench times both the first and the second toggle. A wrong phase or bit-index state corrupts the MOSI word seen by the bench slave and the received word within the same frame. A queue pointer or count error appears as a status flag that differs, or a word returned out of order, at the first status poll or data read that follows.

// File: rtl/spim_pkg.sv
package spim_pkg;
    localparam int BUS_W = 16;

    typedef enum logic [2:0] {
        RI_CTLA = 3'd0,
        RI_CTLB = 3'd1,
        RI_DATA = 3'd2,
        RI_STAT = 3'd3,
        RI_PRE  = 3'd4,
        RI_IRQ  = 3'd5
    } reg_idx_e;

    localparam int CB_LOOP = 3;
    localparam int CB_EN   = 4;
    localparam int CA_POL  = 6;
    localparam int CA_PHA  = 7;

    typedef enum logic {
        SH_IDLE = 1'b0,
        SH_RUN  = 1'b1
    } sh_state_e;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_t;

    fifo_t q, d;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        d = q;
        if (push) begin
            d.mem[q.wp] = wdata;
            d.wp        = bump(q.wp);
        end
        if (pop) begin
            d.rp = bump(q.rp);
        end
        d.cnt = q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rdata = q.mem[q.rp];
    assign count = q.cnt;
    assign empty = (q.cnt == '0);
    assign full  = (q.cnt == CW'(DEPTH));

    // R11
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && full && !pop));

    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop && empty));
endmodule

// File: rtl/spim_clkgen.sv
module spim_clkgen #(
    parameter int PW = 7,
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [PW-1:0] half_pre,
    input  logic [SW-1:0] scr,
    output logic          tick
);
    typedef struct packed {
        logic [PW-1:0] pre;
        logic [SW-1:0] sc;
    } div_t;

    div_t q, d;
    logic [PW-1:0] eff;
    logic          pre_last, sc_last;

    always_comb begin
        eff      = (half_pre == '0) ? PW'(1) : half_pre;
        pre_last = (q.pre == eff - 1'b1);
        sc_last  = (q.sc == scr);
        tick     = run && pre_last && sc_last;
        d        = q;
        if (!run) begin
            d = '0;
        end else if (pre_last) begin
            d.pre = '0;
            d.sc  = sc_last ? '0 : q.sc + 1'b1;
        end else begin
            d.pre = q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/spim_shift.sv
module spim_shift
    import spim_pkg::*;
#(
    parameter int MAXW = 16,
    localparam int LW  = $clog2(MAXW),
    localparam int NW  = $clog2(MAXW + 1),
    localparam int ECW = $clog2(2 * MAXW)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            cpol,
    input  logic            cpha,
    input  logic [LW-1:0]   dss,
    input  logic            tx_avail,
    input  logic [MAXW-1:0] tx_word,
    input  logic            rx_in,
    input  logic            half_tick,
    output logic            tx_pop,
    output logic            done,
    output logic [MAXW-1:0] rx_word,
    output logic            sclk,
    output logic            mosi,
    output logic            fs_n,
    output logic            active
);
    typedef struct packed {
        sh_state_e       st;
        logic            sclk;
        logic            fs_n;
        logic [MAXW-1:0] txsh;
        logic [MAXW-1:0] rxsh;
        logic [NW-1:0]   nb;
        logic [ECW-1:0]  ecnt;
    } sh_t;

    sh_t q, d;
    logic [NW-1:0]   nb_sel;
    logic [ECW-1:0]  last;
    logic            lead, samp;
    logic [MAXW-1:0] out_sh;

    always_comb begin
        d      = q;
        tx_pop = 1'b0;
        done   = 1'b0;
        lead   = ~q.ecnt[0];
        samp   = lead ^ cpha;
        nb_sel = (dss < LW'(3)) ? NW'(4) : NW'(dss) + 1'b1;
        last   = ECW'({q.nb, 1'b0} - 1'b1);
        case (q.st)
            SH_IDLE: begin
                d.sclk = cpol;
                d.fs_n = 1'b1;
                if (en && tx_avail) begin
                    tx_pop = 1'b1;
                    d.st   = SH_RUN;
                    d.fs_n = 1'b0;
                    d.txsh = tx_word;
                    d.rxsh = '0;
                    d.nb   = nb_sel;
                    d.ecnt = '0;
                end
            end
            default: begin
                if (!en) begin
                    d.st   = SH_IDLE;
                    d.sclk = cpol;
                    d.fs_n = 1'b1;
                end else if (half_tick) begin
                    d.sclk = ~q.sclk;
                    if (samp) begin
                        d.rxsh = {q.rxsh[MAXW-2:0], rx_in};
                    end else if (q.ecnt != '0 && q.ecnt != last) begin
                        d.txsh = q.txsh << 1;
                    end
                    if (q.ecnt == last) begin
                        done   = 1'b1;
                        d.st   = SH_IDLE;
                        d.fs_n = 1'b1;
                    end else begin
                        d.ecnt = q.ecnt + 1'b1;
                    end
                end
            end
        endcase
        rx_word = d.rxsh;
        out_sh  = q.txsh >> (q.nb - 1'b1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.fs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sclk   = q.sclk;
    assign mosi   = out_sh[0];
    assign fs_n   = q.fs_n;
    assign active = (q.st == SH_RUN);

    // R4
    fs_during_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SH_RUN) |-> !fs_n);

    // R6
    done_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (q.st == SH_IDLE && fs_n));
endmodule

// File: rtl/spim_top.sv
module spim_top
    import spim_pkg::*;
#(
    parameter int FRAME_MAX  = 16,
    parameter int FIFO_DEPTH = 8,
    localparam int CW        = $clog2(FIFO_DEPTH + 1),
    localparam int LW        = $clog2(FRAME_MAX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic [2:0]       bus_widx,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             spi_sclk,
    output logic             spi_mosi,
    input  logic             spi_miso,
    output logic             spi_fs_n,
    output logic             irq
);
    typedef struct packed {
        logic [15:0] ctla;
        logic [6:0]  ctlb;
        logic [7:0]  pre;
        logic        ovr;
    } regs_t;

    regs_t q, d;

    logic                 wr, rd, clr_wr;
    logic                 tx_push, tx_pop, tx_empty, tx_full;
    logic                 rx_push, rx_pop, rx_empty, rx_full;
    logic [FRAME_MAX-1:0] tx_head, rx_head, rx_word;
    logic [CW-1:0]        tx_cnt, rx_cnt;
    logic                 sh_done, sh_active, half_tick, loop_in;
    logic [2:0]           ris;
    logic [4:0]           stat;

    assign wr      = bus_sel && bus_we;
    assign rd      = bus_sel && !bus_we;
    assign clr_wr  = wr && (bus_widx == RI_IRQ);
    assign tx_push = wr && (bus_widx == RI_DATA) && !tx_full;
    assign rx_pop  = rd && (bus_widx == RI_DATA) && !rx_empty;
    assign rx_push = sh_done && !rx_full;
    assign loop_in = q.ctlb[CB_LOOP] ? spi_mosi : spi_miso;

    always_comb begin
        d = q;
        if (wr) begin
            case (bus_widx)
                RI_CTLA: d.ctla = bus_wdata;
                RI_CTLB: d.ctlb = bus_wdata[6:0];
                RI_PRE:  d.pre  = bus_wdata[7:0];
                RI_IRQ:  d.ovr  = 1'b0;
                default: ;
            endcase
        end
        if (sh_done && rx_full) d.ovr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        ris  = {q.ovr, (tx_cnt <= CW'(FIFO_DEPTH / 2)), (rx_cnt >= CW'(FIFO_DEPTH / 2))};
        stat = {sh_active || !tx_empty, rx_full, !rx_empty, !tx_full, tx_empty};
        case (bus_widx)
            RI_CTLA: bus_rdata = q.ctla;
            RI_CTLB: bus_rdata = BUS_W'(q.ctlb);
            RI_DATA: bus_rdata = rx_empty ? '0 : BUS_W'(rx_head);
            RI_STAT: bus_rdata = BUS_W'(stat);
            RI_PRE:  bus_rdata = BUS_W'(q.pre);
            RI_IRQ:  bus_rdata = BUS_W'(ris);
            default: bus_rdata = '0;
        endcase
    end

    assign irq = |(ris & q.ctlb[2:0]);

    spim_fifo #(.W(FRAME_MAX), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(bus_wdata[FRAME_MAX-1:0]),
        .pop(tx_pop), .rdata(tx_head), .count(tx_cnt), .empty(tx_empty), .full(tx_full)
    );

    spim_fifo #(.W(FRAME_MAX), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_word),
        .pop(rx_pop), .rdata(rx_head), .count(rx_cnt), .empty(rx_empty), .full(rx_full)
    );

    spim_clkgen #(.PW(7), .SW(8)) u_div (
        .clk(clk), .rst_n(rst_n), .run(sh_active), .half_pre(q.pre[7:1]),
        .scr(q.ctla[15:8]), .tick(half_tick)
    );

    spim_shift #(.MAXW(FRAME_MAX)) u_sh (
        .clk(clk), .rst_n(rst_n), .en(q.ctlb[CB_EN]), .cpol(q.ctla[CA_POL]),
        .cpha(q.ctla[CA_PHA]), .dss(q.ctla[LW-1:0]), .tx_avail(!tx_empty),
        .tx_word(tx_head), .rx_in(loop_in), .half_tick(half_tick), .tx_pop(tx_pop),
        .done(sh_done), .rx_word(rx_word), .sclk(spi_sclk), .mosi(spi_mosi),
        .fs_n(spi_fs_n), .active(sh_active)
    );

    // R10
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ovr && !clr_wr) |=> q.ovr);

    // R9
    idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q.ctlb[CB_EN] |=> !sh_active);
endmodule

// File: tb/tb_spim_top.sv
`timescale 1ns/1ps
module tb_spim_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [2:0]  bus_widx = '0;
    logic [15:0] bus_wdata = '0, bus_rdata;
    logic        spi_sclk, spi_mosi, spi_fs_n, irq;
    logic        spi_miso = 1'b0;

    int checks = 0, fails = 0, cyc = 0;

    always #2 clk = ~clk;

    spim_top dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_widx(bus_widx),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_fs_n(spi_fs_n), .irq(irq)
    );

    // bench slave model
    logic        cfg_cpol = 0, cfg_cpha = 0;
    int          cfg_nb = 8;
    logic [15:0] sl_word = '0, mon_word = '0;
    int          sl_cnt = 0, tog_cnt = 0;
    bit          in_frame = 0;
    realtime     t_fs = 0, t_prev = 0, t_first = 0, t_second = 0;

    task automatic sl_drive();
        if (sl_cnt < cfg_nb) spi_miso = sl_word[cfg_nb - 1 - sl_cnt];
        sl_cnt++;
    endtask

    always @(negedge spi_fs_n) begin
        in_frame = 1; mon_word = '0; sl_cnt = 0; tog_cnt = 0; t_fs = $realtime;
        if (!cfg_cpha) sl_drive();
    end

    always @(spi_sclk) begin
        if (in_frame) begin
            if (tog_cnt == 0) t_first = $realtime - t_fs;
            if (tog_cnt == 1) t_second = $realtime - t_prev;
            t_prev = $realtime;
            tog_cnt++;
            if (((spi_sclk != cfg_cpol) ? 1'b1 : 1'b0) ^ cfg_cpha) mon_word = {mon_word[14:0], spi_mosi};
            else sl_drive();
            if (tog_cnt == 2 * cfg_nb) in_frame = 0;
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [15:0] v);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_widx = idx; bus_wdata = v;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic rd(input logic [2:0] idx, output logic [15:0] v);
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_widx = idx;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic wait_idle();
        logic [15:0] s;
        for (int i = 0; i < 5000; i++) begin
            rd(3'd3, s);
            if (!s[4]) return;
        end
    endtask

    typedef struct packed {
        logic        cpol, cpha, lbm;
        logic [3:0]  dss;
        logic [7:0]  cpsr, scr;
        logic [15:0] tx, sw;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 1'b0, 1'b1, 4'd7,  8'd2, 8'd0, 16'h00A5, 16'h005A},
        '{1'b1, 1'b0, 1'b0, 4'd7,  8'd4, 8'd1, 16'h003C, 16'h0096},
        '{1'b0, 1'b1, 1'b0, 4'd15, 8'd2, 8'd2, 16'hBEEF, 16'h1234},
        '{1'b1, 1'b1, 1'b1, 4'd3,  8'd6, 8'd0, 16'h000D, 16'h0002},
        '{1'b0, 1'b0, 1'b0, 4'd1,  8'd3, 8'd0, 16'hFFF9, 16'h0006},
        '{1'b1, 1'b1, 1'b0, 4'd11, 8'd0, 8'd3, 16'h0ABC, 16'h05A5}
    };

    initial begin
        logic [15:0] v, mask, exp_rx;
        int nb, k, half;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        @(negedge clk); #1;
        chk("R1 sclk", spi_sclk, 0);
        chk("R1 fs_n", spi_fs_n, 1);
        chk("R1 irq", irq, 0);
        rd(3'd3, v); chk("R1 R7 status", v, 16'h03);
        rd(3'd5, v); chk("R1 raw irq", v, 16'h2);
        rd(3'd0, v); chk("R1 ctla", v, 0);
        rd(3'd4, v); chk("R1 prescale", v, 0);
        rd(3'd2, v); chk("R11 empty read", v, 0);

        // vector table
        foreach (VECS[i]) begin
            wr(3'd1, 16'h0000);
            wr(3'd0, {VECS[i].scr, VECS[i].cpha, VECS[i].cpol, 2'b00, VECS[i].dss});
            wr(3'd4, {8'h00, VECS[i].cpsr});
            nb   = (VECS[i].dss < 3) ? 4 : int'(VECS[i].dss) + 1;
            mask = 16'((32'h1 << nb) - 1);
            half = (VECS[i].cpsr >> 1) == 0 ? 1 : int'(VECS[i].cpsr >> 1);
            k    = half * (1 + int'(VECS[i].scr));
            cfg_cpol = VECS[i].cpol; cfg_cpha = VECS[i].cpha; cfg_nb = nb;
            sl_word  = VECS[i].lbm ? ~VECS[i].tx : VECS[i].sw;
            @(negedge clk); #1;
            chk("R3 idle level", spi_sclk, VECS[i].cpol);
            wr(3'd1, 16'h0010 | (16'(VECS[i].lbm) << 3));
            wr(3'd2, VECS[i].tx);
            wait_idle();
            exp_rx = (VECS[i].lbm ? VECS[i].tx : VECS[i].sw) & mask;
            rd(3'd2, v);
            chk(VECS[i].lbm ? "R12 loopback rx" : "R4 R5 rx word", v, exp_rx);
            chk("R4 R5 mosi word", mon_word, VECS[i].tx & mask);
            chk("R5 edge count", tog_cnt, 2 * nb);
            chk("R2 first half period", longint'(t_first), 4 * k);
            chk("R2 half period", longint'(t_second), 4 * k);
            chk("R3 rest after frame", spi_sclk, VECS[i].cpol);
            chk("R5 fs released", spi_fs_n, 1);
        end

        // R9 disabled port holds queue
        cfg_cpol = 1; cfg_cpha = 0; cfg_nb = 8;
        wr(3'd1, 16'h0008);
        wr(3'd0, 16'h0047);
        wr(3'd4, 16'h0002);
        wr(3'd2, 16'h0011); wr(3'd2, 16'h0022); wr(3'd2, 16'h0033);
        repeat (40) @(negedge clk);
        #1;
        chk("R9 sclk idle", spi_sclk, 1);
        chk("R9 fs idle", spi_fs_n, 1);
        rd(3'd3, v); chk("R8 R9 status busy", v, 16'h12);
        wr(3'd1, 16'h0018);
        wait_idle();
        rd(3'd2, v); chk("R6 order 1", v, 16'h11);
        rd(3'd2, v); chk("R6 order 2", v, 16'h22);
        rd(3'd2, v); chk("R6 order 3", v, 16'h33);
        rd(3'd3, v); chk("R7 R8 status idle", v, 16'h03);

        // R11 full queue, R10 overrun, R13 interrupts
        wr(3'd1, 16'h000C);
        for (int j = 1; j <= 10; j++) wr(3'd2, 16'(j));
        rd(3'd3, v); chk("R11 R7 tx full status", v, 16'h10);
        wr(3'd1, 16'h001C);
        wait_idle();
        rd(3'd3, v); chk("R7 rx full status", v, 16'h0F);
        rd(3'd5, v); chk("R13 raw irq", v, 16'h3);
        chk("R13 irq masked", irq, 0);
        wr(3'd2, 16'h00AA);
        wait_idle();
        rd(3'd5, v); chk("R10 overrun set", v, 16'h7);
        @(negedge clk); #1;
        chk("R13 irq overrun", irq, 1);
        wr(3'd5, 16'h0000);
        rd(3'd5, v); chk("R10 overrun cleared", v, 16'h3);
        chk("R13 irq low", irq, 0);
        for (int j = 1; j <= 8; j++) begin
            rd(3'd2, v); chk("R6 R11 drain", v, j);
        end
        rd(3'd2, v); chk("R11 empty read", v, 0);
        rd(3'd3, v); chk("R7 final status", v, 16'h03);

        summary();
        $finish;
    end
endmodule